// File: doc/BRIEF.md
# Dual-Channel Fine-Adjust PWM D/A Generator

This block turns two 14-bit digital codes into two pulse-width-modulated output pins whose long-term average tracks the code with full 14-bit resolution. A shared free-running 14-bit counter is split into a position inside a short base cycle and an index of the base cycle within the full count period. The upper code bits set how many counter steps of each base cycle the pin is active. The remaining lower code bits decide in which base cycles one extra active step is appended, so the extra steps are spread evenly over the whole period. An external low-pass filter on the pin then gives the analog level.

Software reaches the block through a two-word register window with a bank-select bit. One bank holds the two data registers. The other holds a control byte (enable, per-pin output enable, polarity, clock divider) and a read-only view of the counter. Each data register carries its own carrier bit, which picks a 64-step or a 256-step base cycle. A code whose base-cycle duty field is zero lies outside the legal range for that carrier setting, and the pin then rests at its inactive level.

Top module: `pwmda_top`

## Requirements
- R1: After reset both data words read 0xFFFF, the control word reads 0xFF30, the counter reads 0, and both pins are 0.
- R2: Bit 0 of the word at address 1 is the bank select (reset 1). With select 0, address 0 is data word A and address 1 is data word B, whose bit 0 is the select itself. With select 1, address 0 shows the control byte in bits 7:0 with bits 15:8 reading 1, and address 1 shows the counter in bits 15:2, 1 in bit 1 and the select in bit 0. A write to address 1 with select 1 changes only the select.
- R3: Bit 0 of data word A ignores writes and always reads 1.
- R4: Control byte: bit 7 test (stored, no effect on pins or counter), bit 6 enable, bits 5:4 read 1, bit 3 pin B enable, bit 2 pin A enable, bit 1 polarity, bit 0 clock divider select. Writable bits reset to 0.
- R5: With enable 0 the counter is held at 0. With enable 1 it advances by one per clock when the divider select is 0, and by one every second clock when it is 1, wrapping modulo 2^14.
- R6: Each data word holds the code in bits 15:2 and the carrier bit in bit 1. Carrier 1: base position is counter[7:0], duty field is code[13:6]. Carrier 0: base position is counter[5:0], duty field is code[13:8]. The channel is active while the base position is less than the duty field plus the extra step of R7.
- R7: The fine field is the code bits below the duty field. With the base-cycle index (the counter bits above the base position) written in reversed bit order, the extra step is 1 when that reversed index is less than the fine field.
- R8: When the duty field is 0 (data word below 0x0103 for carrier 1, below 0x0401 for carrier 0), the channel is never active.
- R9: Each pin equals its enabled channel activity XOR polarity when its output enable is 1, and equals the polarity bit when it is 0. With enable 0 the channel is never active.
- R10: Each pin is registered: after a clock edge it shows the value computed from the counter, data words and control bits as they stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 1 | Word address within the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word (combinational) |
| pwm_a | output | 1 | Channel A PWM pin |
| pwm_b | output | 1 | Channel B PWM pin |

## Verification
The hardest situation to reach is the placement of the extra step across base cycles. It depends on the upper counter bits, so a code with many fine bits shows its full pattern only over a whole 16384-step period. The stimulus therefore runs one carrier-1 setting for more than a full period. It also uses carrier-0 fine codes with a single high bit, whose pattern (every second base cycle) repeats within a few hundred clocks. The boundary codes sit exactly at the smallest legal word and one step below it for each carrier. A bench model recomputes every pin each cycle from its own copy of the counter and registers.

// File: rtl/pwmda_pkg.sv
// Shared constants and types for the fine-adjust PWM D/A generator.
// Assumes the register window is two words wide and 16-bit words hold a 14-bit code.
package pwmda_pkg;
    localparam int unsigned PWM_CODE_W       = 14;
    localparam int unsigned PWM_WIDE_BASE_W  = 8;
    localparam int unsigned PWM_NARROW_BASE_W = 6;
    localparam int unsigned PWM_CHANNELS     = 2;

    // Writable control bits that drive logic (the test bit is kept apart).
    typedef struct packed {
        logic pwm_en;
        logic oe_b;
        logic oe_a;
        logic pol;
        logic clk_sel;
    } pwm_ctrl_t;
endpackage

// File: rtl/pwmda_regs.sv
// Register window: two data words, control byte and counter view behind a
// bank-select bit. Assumes single-cycle word writes; reads are combinational.
module pwmda_regs
    import pwmda_pkg::*;
#(
    parameter int unsigned CODE_W = PWM_CODE_W,
    parameter int unsigned NCH    = PWM_CHANNELS,
    localparam int unsigned REG_W = CODE_W + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       addr,
    input  logic [REG_W-1:0]           wdata,
    input  logic [CODE_W-1:0]          cnt,
    output logic [REG_W-1:0]           rdata,
    output logic [NCH-1:0][CODE_W-1:0] code_o,
    output logic [NCH-1:0]             wide_o,
    output pwm_ctrl_t                  ctrl_o
);
    localparam int unsigned HI_W = REG_W - 8;

    logic [NCH-1:0][REG_W-1:1] data_q;
    logic                      regsel_q;
    logic                      test_q;
    pwm_ctrl_t                 ctrl_q;
    logic [7:0]                ctrl_byte;

    // Register writes, steered by the bank select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '1;
            regsel_q <= 1'b1;
            test_q   <= 1'b0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            if (!addr) begin
                if (regsel_q) begin
                    test_q <= wdata[7];
                    ctrl_q <= '{pwm_en: wdata[6], oe_b: wdata[3], oe_a: wdata[2],
                                pol: wdata[1], clk_sel: wdata[0]};
                end else begin
                    data_q[0] <= wdata[REG_W-1:1];
                end
            end else begin
                regsel_q <= wdata[0];
                if (!regsel_q) begin
                    data_q[1] <= wdata[REG_W-1:1];
                end
            end
        end
    end

    // Read multiplexer for the addressed word.
    always_comb begin
        ctrl_byte = {test_q, ctrl_q.pwm_en, 2'b11, ctrl_q.oe_b, ctrl_q.oe_a,
                     ctrl_q.pol, ctrl_q.clk_sel};
        if (!addr) begin
            rdata = regsel_q ? {{HI_W{1'b1}}, ctrl_byte} : {data_q[0], 1'b1};
        end else begin
            rdata = regsel_q ? {cnt, 1'b1, 1'b1} : {data_q[1], 1'b0};
        end
    end

    // Per-channel code and carrier fields out to the channels.
    for (genvar g = 0; g < NCH; g++) begin : g_fields
        assign code_o[g] = data_q[g][REG_W-1:2];
        assign wide_o[g] = data_q[g][1];
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/pwmda_timebase.sv
// Shared free-running resolution counter with an optional divide-by-two.
// Assumes run/slow come from registered control bits.
module pwmda_timebase #(
    parameter int unsigned CODE_W = pwmda_pkg::PWM_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              slow,
    output logic [CODE_W-1:0] cnt
);
    logic pre_q;

    // Counter advance: every clock, or every second clock when slow.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            pre_q <= 1'b0;
        end else if (!slow) begin
            cnt   <= cnt + 1'b1;
            pre_q <= 1'b0;
        end else begin
            pre_q <= ~pre_q;
            if (pre_q) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwmda_slice.sv
// Compare logic for one carrier variant: duty compare plus fine-step placement.
// Assumes BASE_W < CODE_W; purely combinational.
module pwmda_slice #(
    parameter int unsigned CODE_W = pwmda_pkg::PWM_CODE_W,
    parameter int unsigned BASE_W = pwmda_pkg::PWM_WIDE_BASE_W
) (
    input  logic [CODE_W-1:0] cnt,
    input  logic [CODE_W-1:0] code,
    output logic              hit,
    output logic              in_range
);
    localparam int unsigned FINE_W = CODE_W - BASE_W;

    logic [BASE_W-1:0] base_pos;
    logic [BASE_W-1:0] duty;
    logic [FINE_W-1:0] cyc_idx;
    logic [FINE_W-1:0] cyc_rev;
    logic [FINE_W-1:0] fine;
    logic              extra;

    assign base_pos = cnt[BASE_W-1:0];
    assign cyc_idx  = cnt[CODE_W-1:BASE_W];
    assign duty     = code[CODE_W-1:FINE_W];
    assign fine     = code[FINE_W-1:0];

    // Reverse the base-cycle index so extra steps spread evenly.
    for (genvar i = 0; i < FINE_W; i++) begin : g_rev
        assign cyc_rev[i] = cyc_idx[FINE_W-1-i];
    end

    assign extra    = (cyc_rev < fine);
    assign in_range = |duty;
    assign hit      = ({1'b0, base_pos} < ({1'b0, duty} + {{BASE_W{1'b0}}, extra}));
endmodule

// File: rtl/pwmda_chan.sv
// One PWM channel: both carrier variants, carrier mux, range gate and pin register.
// Assumes the code and carrier bit are stable register outputs.
module pwmda_chan #(
    parameter int unsigned CODE_W        = pwmda_pkg::PWM_CODE_W,
    parameter int unsigned WIDE_BASE_W   = pwmda_pkg::PWM_WIDE_BASE_W,
    parameter int unsigned NARROW_BASE_W = pwmda_pkg::PWM_NARROW_BASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cnt,
    input  logic [CODE_W-1:0] code,
    input  logic              wide,
    input  logic              run,
    input  logic              oe,
    input  logic              pol,
    output logic              pin,
    output logic              in_range
);
    logic [1:0] hit_m;
    logic [1:0] rng_m;
    logic       active;

    // Variant 0 is the short base cycle, variant 1 the long one.
    for (genvar m = 0; m < 2; m++) begin : g_mode
        localparam int unsigned BW = (m == 1) ? WIDE_BASE_W : NARROW_BASE_W;
        pwmda_slice #(.CODE_W(CODE_W), .BASE_W(BW)) u_slice (
            .cnt      (cnt),
            .code     (code),
            .hit      (hit_m[m]),
            .in_range (rng_m[m])
        );
    end

    assign in_range = rng_m[wide];
    assign active   = run & rng_m[wide] & hit_m[wide];

    // Pin register: enabled activity with polarity, else the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else begin
            pin <= oe ? (active ^ pol) : pol;
        end
    end
endmodule

// File: rtl/pwmda_top.sv
// Top of the dual-channel fine-adjust PWM D/A generator: register window,
// shared counter and two channels. Assumes one clock domain.
module pwmda_top
    import pwmda_pkg::*;
#(
    parameter int unsigned CODE_W        = PWM_CODE_W,
    parameter int unsigned WIDE_BASE_W   = PWM_WIDE_BASE_W,
    parameter int unsigned NARROW_BASE_W = PWM_NARROW_BASE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_addr,
    input  logic [CODE_W+1:0]   bus_wdata,
    output logic [CODE_W+1:0]   bus_rdata,
    output logic                pwm_a,
    output logic                pwm_b
);
    localparam int unsigned NCH = PWM_CHANNELS;

    logic [CODE_W-1:0]          cnt;
    logic [NCH-1:0][CODE_W-1:0] ch_code;
    logic [NCH-1:0]             ch_wide;
    logic [NCH-1:0]             ch_oe;
    logic [NCH-1:0]             ch_pin;
    logic [NCH-1:0]             ch_in_range;
    pwm_ctrl_t                  ctrl;

    pwmda_regs #(.CODE_W(CODE_W), .NCH(NCH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cnt    (cnt),
        .rdata  (bus_rdata),
        .code_o (ch_code),
        .wide_o (ch_wide),
        .ctrl_o (ctrl)
    );

    pwmda_timebase #(.CODE_W(CODE_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.pwm_en),
        .slow  (ctrl.clk_sel),
        .cnt   (cnt)
    );

    assign ch_oe = {ctrl.oe_b, ctrl.oe_a};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwmda_chan #(
            .CODE_W        (CODE_W),
            .WIDE_BASE_W   (WIDE_BASE_W),
            .NARROW_BASE_W (NARROW_BASE_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt),
            .code     (ch_code[g]),
            .wide     (ch_wide[g]),
            .run      (ctrl.pwm_en),
            .oe       (ch_oe[g]),
            .pol      (ctrl.pol),
            .pin      (ch_pin[g]),
            .in_range (ch_in_range[g])
        );
    end

    assign pwm_a = ch_pin[0];
    assign pwm_b = ch_pin[1];
endmodule

// Property checker for pwmda_top: counter stepping, idle levels and range hold.
// Assumes it is attached through the bind below.
module pwmda_chk #(
    parameter int unsigned CODE_W = pwmda_pkg::PWM_CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] cnt,
    input logic              run,
    input logic              slow,
    input logic              pol,
    input logic              oe_a,
    input logic              oe_b,
    input logic              rng_a,
    input logic              rng_b,
    input logic              pin_a,
    input logic              pin_b
);
    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !run) |=> (cnt == '0));
    // R5
    cnt_fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && run && !slow) |=> (cnt == CODE_W'($past(cnt) + 1'b1)));
    // R5
    cnt_slow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && run && slow) |=> ((cnt == $past(cnt)) || (cnt == CODE_W'($past(cnt) + 1'b1))));
    // R9
    idle_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !oe_a) |=> (pin_a == $past(pol)));
    // R9
    idle_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !oe_b) |=> (pin_b == $past(pol)));
    // R8
    range_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && oe_a && !rng_a) |=> (pin_a == $past(pol)));
    // R8
    range_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && oe_b && !rng_b) |=> (pin_b == $past(pol)));
endmodule

bind pwmda_top pwmda_chk #(.CODE_W(CODE_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt),
    .run   (ctrl.pwm_en),
    .slow  (ctrl.clk_sel),
    .pol   (ctrl.pol),
    .oe_a  (ctrl.oe_a),
    .oe_b  (ctrl.oe_b),
    .rng_a (ch_in_range[0]),
    .rng_b (ch_in_range[1]),
    .pin_a (ch_pin[0]),
    .pin_b (ch_pin[1])
);

// File: tb/sim_pwmda_top.sv
`timescale 1ns/1ps
module sim_pwmda_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pwm_a, pwm_b;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    mon_cnt = 0;
    string tag = "R1";

    // Bench model state
    logic [15:0] m_a, m_b;
    logic [7:0]  m_ctrl;
    int          m_cnt;
    bit          m_pre;
    logic [1:0]  exp_q[$];

    always #4 clk = ~clk;

    pwmda_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    function automatic logic pin_of(logic [15:0] d, logic oe, logic [7:0] c, int cnt);
        int code, units, fw, duty, fine, cyc, base, rev;
        bit act;
        code  = int'(d >> 2);
        units = d[1] ? 256 : 64;
        fw    = d[1] ? 6 : 8;
        duty  = code >> fw;
        fine  = code & ((1 << fw) - 1);
        cyc   = cnt / units;
        base  = cnt % units;
        rev   = 0;
        for (int j = 0; j < fw; j++) rev |= ((cyc >> j) & 1) << (fw - 1 - j);
        act = c[6] && (duty != 0) && (base < duty + ((rev < fine) ? 1 : 0));
        return oe ? (act ^ c[1]) : c[1];
    endfunction

    // Model: push the pin pair the design registers at this edge, then step state.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 16'hFFFF; m_b = 16'hFFFF; m_ctrl = 8'h30; m_cnt = 0; m_pre = 0;
            exp_q.push_back(2'b00);
        end else begin
            exp_q.push_back({pin_of(m_b, m_ctrl[3], m_ctrl, m_cnt),
                             pin_of(m_a, m_ctrl[2], m_ctrl, m_cnt)});
            if (!m_ctrl[6]) begin m_cnt = 0; m_pre = 0; end
            else if (!m_ctrl[0]) begin m_cnt = (m_cnt + 1) % 16384; m_pre = 0; end
            else begin if (m_pre) m_cnt = (m_cnt + 1) % 16384; m_pre = !m_pre; end
            if (bus_wr) begin
                if (!bus_addr) begin
                    if (m_b[0]) m_ctrl = (bus_wdata[7:0] & 8'hCF) | 8'h30;
                    else m_a = bus_wdata | 16'h0001;
                end else begin
                    if (m_b[0]) m_b[0] = bus_wdata[0];
                    else m_b = bus_wdata;
                end
            end
        end
    end

    // Monitor: compare pins with the scoreboard, optionally the counter view.
    always @(negedge clk) begin
        if (!done && exp_q.size() > 0) begin
            logic [1:0] e;
            e = exp_q.pop_front();
            n_cmp++;
            if ({pwm_b, pwm_a} !== e) begin
                n_bad++;
                $display("FAIL %s pins b,a act=%b exp=%b t=%0t", tag, {pwm_b, pwm_a}, e, $time);
            end
        end
        if (!done && mon_cnt && rst_n) begin
            n_cmp++;
            if (bus_rdata[15:2] !== 14'(m_cnt)) begin
                n_bad++;
                $display("FAIL R5 counter act=%h exp=%h", bus_rdata[15:2], 14'(m_cnt));
            end
        end
    end

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_check(input string t, input logic a, input logic [15:0] e);
        @(negedge clk);
        bus_addr = a;
        #1;
        n_cmp++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s read addr%0d act=%h exp=%h", t, a, bus_rdata, e);
        end
    endtask

    // Program both data words and the control byte; leaves bank select at 1.
    task automatic setup(input logic [15:0] a, input logic [15:0] b, input logic [7:0] c);
        if (m_b[0]) bus_write(1'b1, 16'h0000);
        bus_write(1'b0, a);
        bus_write(1'b1, b | 16'h0001);
        bus_write(1'b0, {8'h00, c});
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values (bank select resets to 1)
        bus_check("R1", 1'b1, 16'h0003);
        bus_check("R1", 1'b0, 16'hFF30);
        // R2 bank switch by writing only the select
        bus_write(1'b1, 16'h0000);
        bus_check("R1", 1'b0, 16'hFFFF);
        bus_check("R2", 1'b1, 16'hFFFE);
        // R3 reserved bit of data word A
        bus_write(1'b0, 16'h1234);
        bus_check("R3", 1'b0, 16'h1235);
        bus_write(1'b1, 16'h4321);
        bus_check("R2", 1'b0, 16'hFF30);
        bus_write(1'b1, 16'h0000);
        bus_check("R2", 1'b1, 16'h4320);
        // R4 control byte readback
        bus_write(1'b1, 16'h0001);
        bus_write(1'b0, 16'h00FF);
        bus_check("R4", 1'b0, 16'hFFFF);
        bus_write(1'b0, 16'h0000);
        bus_check("R4", 1'b0, 16'hFF30);

        // R6 R10 long carrier, full period so every fine placement occurs (R7)
        tag = "R6 R7 R10";
        setup(16'h1002, 16'h80FE, 8'h4C);
        repeat (16500) @(negedge clk);
        // R7 short carrier, single-bit and full fine fields
        tag = "R7";
        setup(16'h1600, 16'hFFFD, 8'h4C);
        repeat (3000) @(negedge clk);
        // R8 one step below the legal range, inverted polarity
        tag = "R8";
        setup(16'h00FF, 16'h03FD, 8'h4E);
        repeat (600) @(negedge clk);
        // R9 smallest legal words, pin A only, inverted polarity
        tag = "R9";
        setup(16'h0103, 16'h0401, 8'h46);
        repeat (1000) @(negedge clk);
        tag = "R9";
        setup(16'h4A52, 16'h2D85, 8'h48);
        repeat (800) @(negedge clk);
        // R5 divided clock, counter view compared every cycle
        tag = "R5";
        setup(16'h2283, 16'h6A70, 8'h4D);
        @(negedge clk); bus_addr = 1'b1; mon_cnt = 1;
        repeat (4000) @(negedge clk);
        mon_cnt = 0;
        // R4 test bit has no effect on pins or counter
        tag = "R4";
        setup(16'h3C8B, 16'hA130, 8'hCC);
        @(negedge clk); bus_addr = 1'b1; mon_cnt = 1;
        repeat (600) @(negedge clk);
        mon_cnt = 0;
        // R5 disable holds counter at 0
        tag = "R5";
        bus_write(1'b0, 16'h000C);
        @(negedge clk); bus_addr = 1'b1; mon_cnt = 1;
        repeat (100) @(negedge clk);
        mon_cnt = 0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule